// File: doc/BRIEF.md
# Multilevel Prioritized Interrupt Controller

This block sits between a set of peripheral interrupt request lines and a processor core. Each request line has its own two-bit level code, which places it at high, medium or low priority or turns it off. A separate non-maskable request line is also accepted. The block picks the request the core should take next and presents its word-aligned vector address. The presented request and its vector are held until the core acknowledges them.

The block keeps one active flag for each level. On acknowledge it sets the flag for the level it granted. A return-from-interrupt pulse clears only the highest flag that is set. A new request is offered only when its level is strictly above every active level, so handlers nest in the same way as their levels. Within the medium and high levels the source with the smallest index, and so the smallest vector address, wins. The low level can instead use a rotating order that starts just after the last low source granted.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irq_valid` is 0 and `active_lvls` is 4'b0000.
- R2: The vector of source i is `BASE_VEC + 2*i` (0x04 + 2*i by default). The non-maskable vector is `NMI_VEC` (0x02 by default).
- R3: When several levels are eligible, the order is non-maskable first, then high, then medium, then low. Source index plays no part across levels.
- R4: Among eligible sources of one level in fixed order, the lowest index is presented.
- R5: A request is presented only if its level ranks strictly above the highest active level. The ranks are low=1, medium=2, high=3 and non-maskable=4. A request of equal or lower rank stays pending.
- R6: `irq_valid` and `irq_vec` hold their values until `irq_ack` is sampled high. On that edge `irq_valid` falls and the granted level's bit is set in `active_lvls` (bit 0 low, bit 1 medium, bit 2 high, bit 3 non-maskable). The next selection appears one clock later.
- R7: An `irq_ret` pulse clears only the highest set bit of `active_lvls`.
- R8: `lvl_en` bit 0, 1 and 2 enable low, medium and high. A request of a disabled level is never presented but stays pending, and it is presented once its level is enabled. The non-maskable request ignores `lvl_en`.
- R9: With `rr_en`=1, the search among low sources starts at the index after the last acknowledged low source and wraps at N_SRC-1. Reset sets that index to N_SRC-1. With `rr_en`=0 the search starts at index 0.
- R10: The level code of source i is `src_lvl[2i+1:2i]`: 0 is off, 1 low, 2 medium, 3 high. A source with code 0, or with its request low, is never presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | N_SRC | Peripheral request lines |
| src_lvl | input | 2*N_SRC | Two-bit level code per source |
| lvl_en | input | 3 | Enables for low, medium and high |
| rr_en | input | 1 | Rotating order for low-level sources |
| nmi_req | input | 1 | Non-maskable request |
| irq_ack | input | 1 | Core takes the presented request |
| irq_ret | input | 1 | Return from the current handler |
| irq_valid | output | 1 | A request is presented |
| irq_vec | output | VEC_W | Word address of the presented vector |
| active_lvls | output | 4 | Levels in service: low, medium, high, non-maskable |

## Verification
The assertions assume that the core never raises `irq_ack` and `irq_ret` in the same cycle, and that it pulses `irq_ack` only while `irq_valid` is high. The stimulus keeps to both rules: each acknowledge and return is a single-cycle pulse issued by its own task, and an acknowledge is given only after a presented request has been observed. Request and level inputs change only between edges. Any input change made while a request is waiting for acknowledge is deliberate, to test that the presented values are held.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Rank encoding: 0 none, 1 low, 2 medium, 3 high, 4 non-maskable
  typedef logic [2:0] rank_t;

  localparam rank_t RANK_NONE = 3'd0;
  localparam rank_t RANK_LOW  = 3'd1;
  localparam rank_t RANK_MED  = 3'd2;
  localparam rank_t RANK_HIGH = 3'd3;
  localparam rank_t RANK_NMI  = 3'd4;

  // Highest rank present in an active-flag set
  function automatic rank_t top_rank(input logic [3:0] act);
    if (act[3])      return RANK_NMI;
    else if (act[2]) return RANK_HIGH;
    else if (act[1]) return RANK_MED;
    else if (act[0]) return RANK_LOW;
    return RANK_NONE;
  endfunction

  // Active-flag bit that belongs to a rank
  function automatic logic [3:0] rank_bit(input rank_t r);
    case (r)
      RANK_LOW:  return 4'b0001;
      RANK_MED:  return 4'b0010;
      RANK_HIGH: return 4'b0100;
      RANK_NMI:  return 4'b1000;
      default:   return 4'b0000;
    endcase
  endfunction

  // Word address of a source vector: entries two words apart
  function automatic int unsigned src_vector(input int unsigned base,
                                             input int unsigned idx);
    return base + 2 * idx;
  endfunction

endpackage

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick #(
  parameter int N_SRC = 8,
  parameter int IDX_W = 3
) (
  input  logic [N_SRC-1:0] mask,
  input  logic [IDX_W-1:0] start,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Circular search from start, first set bit wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N_SRC; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N_SRC) j = j - N_SRC;
      if (!hit && mask[j]) begin
        hit = 1'b1;
        idx = IDX_W'(j);
      end
    end
  end

endmodule

// File: rtl/irq_act_track.sv
module irq_act_track
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic [3:0] set_bit,
  input  logic       ret,
  output logic [3:0] active,
  output rank_t      cur_rank
);

  logic [3:0] clr_bit;

  assign cur_rank = top_rank(active);
  assign clr_bit  = rank_bit(cur_rank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 4'b0000;
    end else begin
      active <= (active & ~(ret ? clr_bit : 4'b0000))
              | (set_en ? set_bit : 4'b0000);
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int BASE_VEC = 4,
  parameter int NMI_VEC  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_req,
  input  logic [2*N_SRC-1:0]   src_lvl,
  input  logic [2:0]           lvl_en,
  input  logic                 rr_en,
  input  logic                 nmi_req,
  input  logic                 irq_ack,
  input  logic                 irq_ret,
  output logic                 irq_valid,
  output logic [VEC_W-1:0]     irq_vec,
  output logic [3:0]           active_lvls
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int N_LVL = 3;

  // Named internal events for the checker
  rank_t            cur_rank;
  rank_t            pres_rank;
  logic [3:0]       pres_onehot;
  logic             ack_fire;
  rank_t            cand_rank;
  logic [IDX_W-1:0] cand_idx;
  logic [VEC_W-1:0] cand_vec;

  logic [N_SRC-1:0] lvl_mask [N_LVL];
  logic [N_LVL-1:0] lvl_ok;
  logic [N_LVL-1:0] lvl_hit;
  logic [IDX_W-1:0] lvl_idx  [N_LVL];
  logic [IDX_W-1:0] lvl_start[N_LVL];

  logic [IDX_W-1:0] last_low;
  logic [IDX_W-1:0] low_start;
  logic [IDX_W-1:0] pres_idx;

  // Rotating start point for the low level
  assign low_start = !rr_en ? '0 :
                     (int'(last_low) == N_SRC - 1) ? '0 : last_low + 1'b1;

  // Per-level request masks, eligibility and pickers
  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign lvl_mask[l][i] = src_req[i] && (src_lvl[2*i +: 2] == 2'(l + 1));
    end
    assign lvl_ok[l]    = lvl_en[l] && (3'(l + 1) > cur_rank);
    assign lvl_start[l] = (l == 0) ? low_start : '0;

    irq_lvl_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .mask  (lvl_mask[l]),
      .start (lvl_start[l]),
      .hit   (lvl_hit[l]),
      .idx   (lvl_idx[l])
    );
  end

  // Cross-level arbitration
  always_comb begin
    cand_rank = RANK_NONE;
    cand_idx  = '0;
    if (nmi_req && cur_rank < RANK_NMI) begin
      cand_rank = RANK_NMI;
    end else if (lvl_ok[2] && lvl_hit[2]) begin
      cand_rank = RANK_HIGH;
      cand_idx  = lvl_idx[2];
    end else if (lvl_ok[1] && lvl_hit[1]) begin
      cand_rank = RANK_MED;
      cand_idx  = lvl_idx[1];
    end else if (lvl_ok[0] && lvl_hit[0]) begin
      cand_rank = RANK_LOW;
      cand_idx  = lvl_idx[0];
    end
  end

  assign cand_vec = (cand_rank == RANK_NMI) ? VEC_W'(NMI_VEC)
                  : VEC_W'(src_vector(BASE_VEC, 32'(cand_idx)));

  // Presentation register: held until acknowledged
  assign ack_fire = irq_valid && irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      pres_rank <= RANK_NONE;
      pres_idx  <= '0;
    end else if (irq_valid) begin
      if (irq_ack) irq_valid <= 1'b0;
    end else if (cand_rank != RANK_NONE) begin
      irq_valid <= 1'b1;
      irq_vec   <= cand_vec;
      pres_rank <= cand_rank;
      pres_idx  <= cand_idx;
    end
  end

  // Last granted low source, for the rotating order
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                last_low <= IDX_W'(N_SRC - 1);
    else if (ack_fire && pres_rank == RANK_LOW) last_low <= pres_idx;
  end

  assign pres_onehot = rank_bit(pres_rank);

  irq_act_track u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (ack_fire),
    .set_bit  (pres_onehot),
    .ret      (irq_ret),
    .active   (active_lvls),
    .cur_rank (cur_rank)
  );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_ack,
  input logic             irq_ret,
  input logic [3:0]       active_lvls,
  input logic [2:0]       pres_rank,
  input logic [3:0]       pres_onehot,
  input logic [2:0]       cur_rank
);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec)); // R6

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid); // R6

  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack && !irq_ret |=>
      (active_lvls & $past(pres_onehot)) == $past(pres_onehot)); // R6

  AST_ONLY_STRICTLY_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> pres_rank > $past(cur_rank)); // R5

  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && pres_rank == 3'd4 |-> irq_vec == VEC_W'(NMI_VEC)); // R2

  AST_RET_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ret && !irq_ack && active_lvls != 4'b0000 |=>
      $countones(active_lvls) + 1 == $past($countones(active_lvls))); // R7

  AST_NO_ACK_WITH_RET: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_ack && irq_ret)); // R6

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (.*);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  localparam int N     = 8;
  localparam int VW    = 8;
  localparam int NTBL  = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_req = '0;
  logic [2*N-1:0] src_lvl = '0;
  logic [2:0]    lvl_en = 3'b111;
  logic          rr_en = 1'b0;
  logic          nmi_req = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_ret = 1'b0;
  logic          irq_valid;
  logic [VW-1:0] irq_vec;
  logic [3:0]    active_lvls;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_lvl(src_lvl),
    .lvl_en(lvl_en), .rr_en(rr_en), .nmi_req(nmi_req), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .active_lvls(active_lvls)
  );

  // {req, lvl codes, enables, nmi, expect valid, expect vector}
  localparam logic [36:0] TBL [NTBL] = '{
    {8'h01, 16'h0001, 3'b111, 1'b0, 1'b1, 8'h04},
    {8'h80, 16'hC000, 3'b111, 1'b0, 1'b1, 8'h12},
    {8'h0C, 16'h0090, 3'b111, 1'b0, 1'b1, 8'h0A},
    {8'h30, 16'h0A00, 3'b111, 1'b0, 1'b1, 8'h0C},
    {8'h06, 16'h0014, 3'b111, 1'b0, 1'b1, 8'h06},
    {8'h01, 16'h0003, 3'b000, 1'b1, 1'b1, 8'h02},
    {8'h01, 16'h0003, 3'b011, 1'b0, 1'b0, 8'h00},
    {8'hFF, 16'h0000, 3'b111, 1'b0, 1'b0, 8'h00},
    {8'h03, 16'h000B, 3'b010, 1'b0, 1'b1, 8'h06},
    {8'h41, 16'h3002, 3'b111, 1'b0, 1'b1, 8'h10},
    {8'h00, 16'hFFFF, 3'b111, 1'b0, 1'b0, 8'h00}
  };

  function automatic string tbl_tag(input int i);
    case (i)
      0, 1:    return "R2";
      2, 9:    return "R3";
      3, 4:    return "R4";
      5, 6, 8: return "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic int exp_vec(input int idx);
    return 4 + idx * 2;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic ret_pulse();
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
  endtask

  task automatic clear_inputs();
    src_req = '0; src_lvl = '0; nmi_req = 1'b0; lvl_en = 3'b111; rr_en = 1'b0;
  endtask

  task automatic do_reset();
    clear_inputs();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    do_reset();
    check("R1 valid", int'(irq_valid), 0);
    check("R1 active", int'(active_lvls), 0);

    // Table walk: each entry from an idle state
    for (int i = 0; i < NTBL; i++) begin
      logic [36:0] e;
      e = TBL[i];
      src_req = e[36:29]; src_lvl = e[28:13]; lvl_en = e[12:10]; nmi_req = e[9];
      tick();
      check({tbl_tag(i), " valid"}, int'(irq_valid), int'(e[8]));
      if (e[8]) check({tbl_tag(i), " vector"}, int'(irq_vec), int'(e[7:0]));
      if (irq_valid) begin
        ack_pulse();
        clear_inputs();
        ret_pulse();
      end else begin
        clear_inputs();
      end
      tick();
    end

    // R5 / R6 / R7: nesting and equal-level blocking
    do_reset();
    src_lvl = 16'h0005; src_req = 8'h03;
    tick();
    check("R4 first low", int'(irq_vec), exp_vec(0));
    ack_pulse();
    check("R6 valid after ack", int'(irq_valid), 0);
    check("R6 low flag", int'(active_lvls), 4'b0001);
    tick();
    check("R5 equal level blocked", int'(irq_valid), 0);
    src_lvl = 16'h0025; src_req = 8'h07;
    tick();
    check("R5 medium preempts", int'(irq_valid), 1);
    check("R5 medium vector", int'(irq_vec), exp_vec(2));
    ack_pulse();
    check("R6 nested flags", int'(active_lvls), 4'b0011);
    src_req = 8'h03;
    ret_pulse();
    check("R7 clears medium only", int'(active_lvls), 4'b0001);
    tick();
    check("R5 low still blocked", int'(irq_valid), 0);
    ret_pulse();
    check("R7 clears low", int'(active_lvls), 4'b0000);
    tick();
    check("R5 low now taken", int'(irq_vec), exp_vec(0));
    ack_pulse(); clear_inputs(); ret_pulse(); tick();

    // R6: hold while waiting, then the non-maskable preempts high
    src_lvl = 16'h0C00; src_req = 8'h20;
    tick();
    check("R2 high src5", int'(irq_vec), exp_vec(5));
    nmi_req = 1'b1;
    tick();
    check("R6 held vector", int'(irq_vec), exp_vec(5));
    ack_pulse();
    check("R6 released", int'(irq_valid), 0);
    tick();
    check("R3 nmi over active high", int'(irq_vec), 2);
    src_req = '0;
    ack_pulse();
    nmi_req = 1'b0;
    check("R6 high+nmi flags", int'(active_lvls), 4'b1100);
    ret_pulse();
    check("R7 clears nmi only", int'(active_lvls), 4'b0100);
    ret_pulse(); tick();

    // R8: disabled level stays pending
    clear_inputs();
    lvl_en = 3'b011; src_lvl = 16'h0003; src_req = 8'h01;
    tick(); tick(); tick();
    check("R8 disabled not shown", int'(irq_valid), 0);
    lvl_en = 3'b111;
    tick();
    check("R8 shown once enabled", int'(irq_vec), exp_vec(0));
    ack_pulse(); clear_inputs(); ret_pulse(); tick();

    // R9: rotating low order
    do_reset();
    rr_en = 1'b1; src_lvl = 16'h0015; src_req = 8'h07;
    tick();
    check("R9 rr first", int'(irq_vec), exp_vec(0));
    ack_pulse(); ret_pulse(); tick();
    check("R9 rr second", int'(irq_vec), exp_vec(1));
    ack_pulse(); ret_pulse(); tick();
    check("R9 rr third", int'(irq_vec), exp_vec(2));
    ack_pulse(); ret_pulse(); tick();
    check("R9 rr wraps", int'(irq_vec), exp_vec(0));
    ack_pulse(); rr_en = 1'b0; ret_pulse(); tick();
    check("R9 fixed restarts at 0", int'(irq_vec), exp_vec(0));
    ack_pulse(); clear_inputs(); ret_pulse(); tick();

    finish_run();
  end

endmodule